// File: doc/BRIEF.md
# Remote-Forwarding I2C Target with Per-Byte Clock Hold

This block is an I2C target that answers on behalf of a device at the far end of a link. Every byte it takes from the bus is passed to a remote agent through a request channel. The matching answer comes back through a response channel. An answer is either an acknowledge bit or, on reads, a data byte. The block never has the answer on hand when the byte ends. So after the eighth data bit of every byte it holds SCL low and waits for the remote agent. This hold happens before the acknowledge clock on writes, and before the first data bit on reads. Once the response has been taken, the block puts the acknowledge or the first read bit on SDA and then lets SCL go.

SCL and SDA are open-drain. The block samples each line and has one pull-low enable per line. A 3-bit select input picks the device address. The request channel uses valid/ready. `req_valid` stays high, and `req_data`, `req_read` and `req_first` stay stable, until a cycle in which `req_ready` is high. After that handshake the block raises `rsp_ready` and waits for `rsp_valid` for as long as it takes, holding SCL the whole time. The remote side may therefore apply back-pressure on either channel without limit. Only one request is ever outstanding.

Top module: `i2c_bridge_slave`

## Requirements
- R1: The select code `addr_sel` gives the 7-bit address: 0 to 0x58, 1 to 0x59, 2 to 0x5A, 3 to 0x5B, 4 to 0x5C, 5 to 0x5E. The codes 6 and 7 fall back to 0x58. The address byte sits in bits 7..1 of the first byte after a START, and bit 0 is the read flag (1 = read).
- R2: When the address byte does not match, no request is issued, SCL is not held, and SDA is not pulled during the acknowledge clock. The block then ignores all bytes until the next START.
- R3: After the falling edge of the eighth clock of a byte that needs the remote side, SCL is held low. The hold lasts from the request until the response has been accepted and one further setup cycle has passed. This applies to every byte separately.
- R4: A request carries the whole address byte in `req_data` with `req_first`=1 and `req_read` equal to the read flag. While `req_valid` is high and `req_ready` is low, all request fields hold steady.
- R5: During the ninth clock of the address byte or a written byte, SDA is pulled low exactly when `rsp_ack`=1. SDA is released after the ninth falling edge.
- R6: Each data byte of a write is forwarded as its own request with `req_first`=0, `req_read`=0 and the byte in `req_data`.
- R7: After an acknowledged read address, the block issues a fetch request with `req_read`=1 and `req_first`=0. It then shifts `rsp_data` out MSB first. SDA changes only while SCL is low.
- R8: After a read byte, an ACK from the controller (SDA low on the ninth clock) starts the next fetch. A NACK ends the read, and no further requests are made until the next START.
- R9: A START (SDA falls while SCL is high) restarts the address phase from any state. A STOP (SDA rises while SCL is high) returns the block to idle, where bytes produce no request.
- R10: If the remote side answers `rsp_ack`=0, SDA stays released on the ninth clock. The block then ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low |
| addr_sel | input | 3 | Device address select code |
| req_valid | output | 1 | Request to the remote side is valid |
| req_ready | input | 1 | Remote side accepts the request |
| req_data | output | 8 | Byte to forward (zero on read fetches) |
| req_read | output | 1 | Request belongs to a read |
| req_first | output | 1 | Request is the address byte |
| rsp_valid | input | 1 | Remote response is valid |
| rsp_ready | output | 1 | Block is waiting for a response |
| rsp_ack | input | 1 | Remote acknowledge for a written byte |
| rsp_data | input | 8 | Remote read data |

## Verification
Both lines pass through two synchronising flops and an edge flop. A START or STOP therefore takes effect 3 clocks after the line changes. A request appears about 4 clocks after the eighth falling edge of SCL. SCL is released 2 clocks after the response handshake, and the acknowledge or first read bit is already on SDA by then. The bench controller holds each SCL phase for 20 clocks. It samples SDA only at the end of a high phase, after it has seen SCL actually high. It samples request fields at the remote handshake. This keeps every check far beyond these latencies. Hold lengths are measured as the cycles SCL stays low after release and are compared with the configured remote delay.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_RX_END, ST_REQ, ST_RSP,
    ST_SETUP, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
  } i2cb_state_e;

  function automatic logic [ADDR_W-1:0] sel_to_addr(input logic [2:0] sel);
    case (sel)
      3'd1:    return 7'h59;
      3'd2:    return 7'h5A;
      3'd3:    return 7'h5B;
      3'd4:    return 7'h5C;
      3'd5:    return 7'h5E;
      default: return 7'h58;
    endcase
  endfunction
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_val,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              req_valid,
  output logic [BYTE_W-1:0] req_data,
  output logic              req_read,
  output logic              req_first,
  output logic              rsp_ready
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  i2cb_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              first;    // current byte is the address byte
  logic              rnw;      // transaction direction
  logic              rd_phase; // outstanding request is a read fetch
  logic              ack_r;    // remote ack (write) or controller ack (read)

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0;
      first <= 1'b0; rnw <= 1'b0; rd_phase <= 1'b0; ack_r <= 1'b0;
    end else if (start_det) begin
      state <= ST_RX; cnt <= '0; first <= 1'b1;
      rnw <= 1'b0; rd_phase <= 1'b0; ack_r <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; rd_phase <= 1'b0; ack_r <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          shreg <= {shreg[BYTE_W-2:0], sda_val};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST_BIT) state <= ST_RX_END;
        end
        ST_RX_END: if (scl_fall) begin
          if (first && shreg[BYTE_W-1:1] != dev_addr) state <= ST_IGNORE;
          else begin
            state    <= ST_REQ;
            rd_phase <= 1'b0;
            if (first) rnw <= shreg[0];
          end
        end
        ST_REQ: if (req_ready) state <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          if (rd_phase) shreg <= rsp_data;
          else          ack_r <= rsp_ack;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt   <= '0;
          state <= rd_phase ? ST_TX : ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          ack_r <= 1'b0;
          first <= 1'b0;
          if (!ack_r)   state <= ST_IGNORE;
          else if (rnw) begin state <= ST_REQ; rd_phase <= 1'b1; end
          else          begin state <= ST_RX;  cnt <= '0; end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == LAST_BIT) state <= ST_MACK;
          else begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (scl_rise) ack_r <= ~sda_val;
          if (scl_fall) begin
            ack_r <= 1'b0;
            state <= ack_r ? ST_REQ : ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    scl_pull  = (state == ST_REQ) || (state == ST_RSP) || (state == ST_SETUP);
    sda_pull  = ((state == ST_SETUP || state == ST_ACK) && !rd_phase && ack_r) ||
                ((state == ST_SETUP || state == ST_TX) && rd_phase && !shreg[BYTE_W-1]);
    req_valid = (state == ST_REQ);
    rsp_ready = (state == ST_RSP);
    req_first = first;
    req_read  = rd_phase | (first & shreg[0]);
    req_data  = rd_phase ? '0 : shreg;
  end
endmodule

// File: rtl/i2c_bridge_slave.sv
module i2c_bridge_slave
  import i2cb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic [2:0]        addr_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BYTE_W-1:0] req_data,
  output logic              req_read,
  output logic              req_first,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ack,
  input  logic [BYTE_W-1:0] rsp_data
);
  localparam int N_LINES = 2; // index 1 = SCL, index 0 = SDA

  logic [N_LINES-1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in[g]),
      .level(line_lvl[g]), .rise(line_rise[g]), .fall(line_fall[g])
    );
  end

  logic start_det, stop_det;
  assign start_det = line_fall[0] & line_lvl[1];
  assign stop_det  = line_rise[0] & line_lvl[1];

  i2cb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(line_rise[1]), .scl_fall(line_fall[1]), .sda_val(line_lvl[0]),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr(sel_to_addr(addr_sel)),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_data(rsp_data),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .req_valid(req_valid), .req_data(req_data), .req_read(req_read),
    .req_first(req_first), .rsp_ready(rsp_ready)
  );
endmodule

// File: rtl/i2c_bridge_slave_chk.sv
module i2c_bridge_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_data,
  input logic       req_read,
  input logic       req_first,
  input logic       rsp_valid,
  input logic       rsp_ready
);
  // R3: clock is held for the whole time a request is pending
  a_r3_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> scl_pull);

  // R3: clock is held while the response is awaited
  a_r3_hold_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> scl_pull);

  // R3: the hold ends two cycles after a response was presented
  a_r3_release_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> $past(rsp_valid, 2));

  // R4: request fields are stable under back-pressure
  a_r4_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_data) &&
                                   $stable(req_read) && $stable(req_first)));

  // R7: SDA drive changes only while SCL is low
  a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_i);
endmodule

bind i2c_bridge_slave i2c_bridge_slave_chk u_chk (.*);

// File: tb/i2c_bridge_slave_bench.sv
module i2c_bridge_slave_bench;
  localparam int HP = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_pull, sda_pull;
  wire  scl_i = scl_m & ~scl_pull;
  wire  sda_i = sda_m & ~sda_pull;
  logic [2:0] addr_sel = 3'd0;
  logic req_valid, req_ready = 1'b0, req_read, req_first, rsp_ready;
  logic [7:0] req_data, rsp_data = 8'h00;
  logic rsp_valid = 1'b0, rsp_ack = 1'b0;

  i2c_bridge_slave u_i2c_bridge_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .addr_sel(addr_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_read(req_read), .req_first(req_first),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  int checks = 0, failures = 0;
  int req_cnt = 0, fetch_n = 0, rdly = 3000;
  bit remote_ack = 1'b1;
  logic [7:0] last_data, last_rsp_data;
  bit last_read, last_first;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic [2:0] s);
    logic [6:0] t [6] = '{7'h58, 7'h59, 7'h5A, 7'h5B, 7'h5C, 7'h5E};
    return (s < 3'd6) ? t[s] : 7'h58;
  endfunction

  function automatic logic [7:0] rd_val(input int k);
    return 8'(k * 59 + 97);
  endfunction

  // remote agent model
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        repeat ($urandom % 4) @(negedge clk);
        last_data = req_data; last_read = req_read; last_first = req_first;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        req_cnt++;
        repeat (rdly) @(negedge clk);
        rsp_ack = remote_ack;
        if (last_read && !last_first) begin
          rsp_data = rd_val(fetch_n); fetch_n++;
        end else rsp_data = 8'($urandom);
        last_rsp_data = rsp_data;
        rsp_valid = 1'b1;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic release_scl(output int st);
    scl_m = 1'b1; st = 0;
    @(negedge clk);
    while (!scl_i) begin st++; @(negedge clk); end
  endtask

  task automatic bit_io(input bit b, output bit s_first, output bit s_last, output int st);
    sda_m = b; tick(HP);
    release_scl(st);
    s_first = sda_i; tick(HP);
    s_last = sda_i; scl_m = 1'b0;
  endtask

  task automatic bus_start();
    int st;
    sda_m = 1'b1; tick(HP);
    release_scl(st); tick(HP);
    sda_m = 1'b0; tick(HP);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    int st;
    sda_m = 1'b0; tick(HP);
    release_scl(st); tick(HP);
    sda_m = 1'b1; tick(HP);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack, output int st);
    bit f, l; int s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], f, l, s);
    bit_io(1'b1, f, l, st);
    ack = !l;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] v, output int st, output bit stab);
    bit f, l; int s;
    stab = 1'b1; st = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, f, l, s);
      if (i == 7) st = s;
      v[i] = l;
      if (f != l) stab = 1'b0;
    end
    bit_io(!mack, f, l, s);
  endtask

  task automatic run_txn(input logic [6:0] a, input bit rnw, input int nb,
                         input bit rem_ack, input int dly, input bit do_stop);
    bit match, exp_ack, ack, stab; int st, c0; logic [7:0] d, v;
    match = (a == exp_addr(addr_sel));
    exp_ack = match && rem_ack;
    remote_ack = rem_ack; rdly = dly;
    c0 = req_cnt;
    bus_start();
    wr_byte({a, rnw}, ack, st);
    if (match) begin
      chk(ack == exp_ack, exp_ack ? "R5 addr ack" : "R10 remote nack", ack, exp_ack);
      chk(req_cnt == c0 + 1, "R1 address match request", req_cnt - c0, 1);
      chk(last_first && last_data == {a, rnw} && last_read == rnw,
          "R4 address request fields", last_data, {a, rnw});
      chk(st > 0 && st >= dly - HP, "R3 address byte hold", st, dly);
    end else begin
      chk(!ack, "R2 mismatch no ack", ack, 0);
      chk(req_cnt == c0 && st == 0, "R2 mismatch no request/hold", req_cnt - c0, 0);
    end
    for (int k = 0; k < nb; k++) begin
      c0 = req_cnt;
      if (!rnw) begin
        d = 8'($urandom);
        wr_byte(d, ack, st);
        if (exp_ack) begin
          chk(ack, "R6 data ack", ack, 1);
          chk(req_cnt == c0 + 1 && last_data == d && !last_first && !last_read,
              "R6 data forwarded", last_data, d);
          chk(st > 0, "R3 per-byte hold", st, 1);
        end else
          chk(!ack && req_cnt == c0, match ? "R10 ignored after nack" : "R2 ignored after mismatch",
              req_cnt - c0, 0);
      end else begin
        rd_byte(k < nb - 1, v, st, stab);
        if (exp_ack) begin
          chk(v == last_rsp_data && last_read && !last_first, "R7 read data", v, last_rsp_data);
          chk(stab, "R7 SDA stable while SCL high", stab, 1);
          chk(req_cnt == c0 + 1 && st > 0, "R8 one fetch per byte", req_cnt - c0, 1);
        end else
          chk(v == 8'hFF && req_cnt == c0, "R2 read ignored", v, 8'hFF);
      end
    end
    if (rnw && exp_ack) begin
      c0 = req_cnt;
      rd_byte(1'b0, v, st, stab);
      chk(v == 8'hFF && req_cnt == c0, "R8 no fetch after NACK", req_cnt - c0, 0);
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    bit ack; int st, c0; logic [6:0] a; int unused;
    unused = $urandom(32'h51C0FFEE);
    tick(5);
    chk(!scl_pull && !sda_pull && !req_valid && !rsp_ready, "R9 reset idle",
        {scl_pull, sda_pull, req_valid, rsp_ready}, 0);
    rst_n = 1'b1; tick(5);

    // directed: long remote delay, write two bytes
    addr_sel = 3'd0;
    run_txn(7'h58, 1'b0, 2, 1'b1, 3000, 1'b1);
    // R9: after STOP a byte draws no request
    c0 = req_cnt;
    scl_m = 1'b0; wr_byte(8'hB0, ack, st);
    chk(req_cnt == c0 && !ack, "R9 idle after stop", req_cnt - c0, 0);
    scl_m = 1'b1; tick(HP); bus_stop();

    // R1 invalid codes fall back
    addr_sel = 3'd7; run_txn(7'h58, 1'b0, 1, 1'b1, 60, 1'b1);
    addr_sel = 3'd6; run_txn(7'h58, 1'b0, 1, 1'b1, 60, 1'b1);
    addr_sel = 3'd5; run_txn(7'h5E, 1'b0, 1, 1'b1, 60, 1'b1);
    // R2 mismatch, then R9 START recovers
    addr_sel = 3'd2; run_txn(7'h58, 1'b0, 2, 1'b1, 60, 1'b1);
    run_txn(7'h5A, 1'b0, 1, 1'b1, 60, 1'b1);
    // R10 remote nack on address
    addr_sel = 3'd4; run_txn(7'h5C, 1'b0, 2, 1'b0, 80, 1'b1);
    // R7/R8 read of three bytes
    addr_sel = 3'd5; run_txn(7'h5E, 1'b1, 3, 1'b1, 150, 1'b1);
    // R9 repeated START: write then read without STOP
    addr_sel = 3'd3;
    run_txn(7'h5B, 1'b0, 1, 1'b1, 70, 1'b0);
    run_txn(7'h5B, 1'b1, 2, 1'b1, 70, 1'b1);

    // constrained random
    for (int it = 0; it < 14; it++) begin
      addr_sel = 3'($urandom % 8);
      a = ($urandom % 4 == 0) ? exp_addr(3'($urandom % 6)) : exp_addr(addr_sel);
      run_txn(a, 1'($urandom % 2), 1 + int'($urandom % 3), ($urandom % 5) != 0,
              40 + int'($urandom % 160), 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule